// File: doc/BRIEF.md
# Inverted Page Table Search Engine

This block translates a pair made of a process identifier and a virtual page number into a physical page number. It searches a table that holds one slot for each physical page of memory. Because all processes share the one table, every slot records which process owns the page and which virtual page of that process it holds. The physical page number is never stored in a slot: it is the position of the slot in the table.

A search starts with a one-cycle `start` pulse that carries the key. The engine then examines one slot per clock, starting at slot 0, and stops at the first valid slot whose owner and virtual page both equal the key. It reports that slot's position together with the number of cycles spent scanning. If no slot matches by the last slot, it reports a page fault instead. The operating-system side fills slots through a write port. That port is locked while a search runs, so the table cannot change in the middle of a scan.

Top module: `ipt_search`

## Requirements
- R1: The table has `DEPTH` slots, all invalid after reset; a write on the load port while the engine is idle stores the valid flag, process ID and virtual page number into slot `ld_slot` at the clock edge.
- R2: A slot matches only if its valid flag is 1 and both its process ID and its virtual page number equal the searched key; an invalid slot or a slot that differs in either field is passed over.
- R3: On a hit, `ppn` equals the index of the lowest-numbered matching slot.
- R4: Slots are examined one per cycle from index 0: a hit in slot k raises `done` k+1 cycles after the edge that accepts `start`, with `scan_cycles` = k+1.
- R5: When no slot matches, `done` rises `DEPTH` cycles after the accepting edge with `fault` = 1, `ppn` = 0 and `scan_cycles` = `DEPTH`; a hit gives `fault` = 0.
- R6: `busy` is 1 from the cycle after the accepting edge until the search ends; `done` is a one-cycle pulse in the first cycle with `busy` back at 0.
- R7: A load-port write while `busy` is 1 changes no slot, and `ld_reject` is 1 in that cycle (0 otherwise).
- R8: A `start` while `busy` is 1 is ignored; the running search completes with its original key.
- R9: After reset `busy`, `done`, `fault`, `ppn` and `scan_cycles` are 0; `fault`, `ppn` and `scan_cycles` keep their values until the next search ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Write strobe for one table slot |
| ld_slot | input | IDX_W | Slot to write |
| ld_valid | input | 1 | Valid flag to store |
| ld_pid | input | PID_W | Owning process ID to store |
| ld_vpn | input | VPN_W | Virtual page number to store |
| ld_reject | output | 1 | Write refused because a search is running |
| start | input | 1 | Begin a search with the key below |
| req_pid | input | PID_W | Process ID of the key |
| req_vpn | input | VPN_W | Virtual page number of the key |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a search ends |
| fault | output | 1 | Last search found no match |
| ppn | output | IDX_W | Physical page number (matching slot index) |
| scan_cycles | output | CNT_W | Cycles spent by the last search |

## Verification
A corrupted slot, key register or scan index shows at the ports no later than the end of the search that touches it: the wrong slot number or a spurious fault appears in the `done` cycle, and a scan index that skips or repeats shows up as `done` arriving early or late against the expected k+1 cycles. A write that leaks through while busy does not change the running search, but the next search of that key returns the wrong slot. Slots placed at index 0, at the last index, duplicated, or invalid with a matching key make each of these faults reach the outputs.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic logic slot_is_last(input int unsigned idx, input int unsigned depth);
        return idx == depth - 1;
    endfunction

endpackage

// File: rtl/ipt_table.sv
module ipt_table #(
    parameter int DEPTH = 16,
    parameter int PID_W = 8,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic             wr_valid,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [IDX_W-1:0] rd_slot,
    output logic             rd_valid,
    output logic [PID_W-1:0] rd_pid,
    output logic [VPN_W-1:0] rd_vpn
);

    logic             slot_valid [DEPTH];
    logic [PID_W-1:0] slot_pid   [DEPTH];
    logic [VPN_W-1:0] slot_vpn   [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_slot == IDX_W'(s));
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid[s] <= 1'b0;
                slot_pid[s]   <= '0;
                slot_vpn[s]   <= '0;
            end else if (sel) begin
                slot_valid[s] <= wr_valid;
                slot_pid[s]   <= wr_pid;
                slot_vpn[s]   <= wr_vpn;
            end
        end
    end

    always_comb begin
        rd_valid = slot_valid[rd_slot];
        rd_pid   = slot_pid[rd_slot];
        rd_vpn   = slot_vpn[rd_slot];
    end

endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
    parameter int PID_W = 8,
    parameter int VPN_W = 20
) (
    input  logic             ent_valid,
    input  logic [PID_W-1:0] ent_pid,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [PID_W-1:0] key_pid,
    input  logic [VPN_W-1:0] key_vpn,
    output logic             hit
);

    logic pid_eq;
    logic vpn_eq;

    always_comb begin
        pid_eq = (ent_pid == key_pid);
        vpn_eq = (ent_vpn == key_vpn);
        hit    = ent_valid && pid_eq && vpn_eq;
    end

endmodule

// File: rtl/ipt_scan_ctrl.sv
module ipt_scan_ctrl
    import ipt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PID_W = 8,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PID_W-1:0] req_pid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             hit,
    output logic [IDX_W-1:0] scan_idx,
    output logic [PID_W-1:0] key_pid,
    output logic [VPN_W-1:0] key_vpn,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [IDX_W-1:0] ppn,
    output logic [CNT_W-1:0] scan_cycles
);

    scan_state_e state_q;

    assign busy = (state_q == ST_SCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            scan_idx    <= '0;
            key_pid     <= '0;
            key_vpn     <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            ppn         <= '0;
            scan_cycles <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_SCAN;
                        scan_idx <= '0;
                        key_pid  <= req_pid;
                        key_vpn  <= req_vpn;
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        state_q     <= ST_IDLE;
                        done        <= 1'b1;
                        fault       <= 1'b0;
                        ppn         <= scan_idx;
                        scan_cycles <= CNT_W'(scan_idx) + CNT_W'(1);
                    end else if (slot_is_last(int'(scan_idx), DEPTH)) begin
                        state_q     <= ST_IDLE;
                        done        <= 1'b1;
                        fault       <= 1'b1;
                        ppn         <= '0;
                        scan_cycles <= CNT_W'(DEPTH);
                    end else begin
                        scan_idx <= scan_idx + IDX_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ipt_search.sv
module ipt_search #(
    parameter int DEPTH = 16,
    parameter int PID_W = 8,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_slot,
    input  logic             ld_valid,
    input  logic [PID_W-1:0] ld_pid,
    input  logic [VPN_W-1:0] ld_vpn,
    output logic             ld_reject,
    input  logic             start,
    input  logic [PID_W-1:0] req_pid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [IDX_W-1:0] ppn,
    output logic [CNT_W-1:0] scan_cycles
);

    logic [IDX_W-1:0] scan_idx;
    logic [PID_W-1:0] key_pid;
    logic [VPN_W-1:0] key_vpn;
    logic             ent_valid;
    logic [PID_W-1:0] ent_pid;
    logic [VPN_W-1:0] ent_vpn;
    logic             hit;
    logic             wr_ok;

    assign wr_ok     = ld_en && !busy;
    assign ld_reject = ld_en && busy;

    ipt_table #(.DEPTH(DEPTH), .PID_W(PID_W), .VPN_W(VPN_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok),
        .wr_slot  (ld_slot),
        .wr_valid (ld_valid),
        .wr_pid   (ld_pid),
        .wr_vpn   (ld_vpn),
        .rd_slot  (scan_idx),
        .rd_valid (ent_valid),
        .rd_pid   (ent_pid),
        .rd_vpn   (ent_vpn)
    );

    ipt_match #(.PID_W(PID_W), .VPN_W(VPN_W)) match_i (
        .ent_valid (ent_valid),
        .ent_pid   (ent_pid),
        .ent_vpn   (ent_vpn),
        .key_pid   (key_pid),
        .key_vpn   (key_vpn),
        .hit       (hit)
    );

    ipt_scan_ctrl #(.DEPTH(DEPTH), .PID_W(PID_W), .VPN_W(VPN_W)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .req_pid     (req_pid),
        .req_vpn     (req_vpn),
        .hit         (hit),
        .scan_idx    (scan_idx),
        .key_pid     (key_pid),
        .key_vpn     (key_vpn),
        .busy        (busy),
        .done        (done),
        .fault       (fault),
        .ppn         (ppn),
        .scan_cycles (scan_cycles)
    );

endmodule

// File: rtl/ipt_search_chk.sv
module ipt_search_chk #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             ld_en,
    input logic             ld_reject,
    input logic             busy,
    input logic             done,
    input logic             fault,
    input logic [IDX_W-1:0] ppn,
    input logic [CNT_W-1:0] scan_cycles
);

    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_reject_only_busy: assert property (@(posedge clk) disable iff (rst)
        ld_reject |-> (busy && ld_en));

    a_r5_fault_full_scan: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (scan_cycles == CNT_W'(DEPTH) && ppn == '0));

    a_r4_hit_cycle_count: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (scan_cycles == CNT_W'(ppn) + CNT_W'(1)));

    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(ppn) && $stable(fault) && $stable(scan_cycles)));

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> (busy || done));

endmodule

bind ipt_search ipt_search_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .ld_en       (ld_en),
    .ld_reject   (ld_reject),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .ppn         (ppn),
    .scan_cycles (scan_cycles)
);

// File: tb/ipt_search_tb_top.sv
module ipt_search_tb_top;

    localparam int DEPTH = 16;
    localparam int PID_W = 8;
    localparam int VPN_W = 20;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ld_en = 1'b0;
    logic [IDX_W-1:0] ld_slot = '0;
    logic             ld_valid = 1'b0;
    logic [PID_W-1:0] ld_pid = '0;
    logic [VPN_W-1:0] ld_vpn = '0;
    logic             ld_reject;
    logic             start = 1'b0;
    logic [PID_W-1:0] req_pid = '0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic             busy;
    logic             done;
    logic             fault;
    logic [IDX_W-1:0] ppn;
    logic [CNT_W-1:0] scan_cycles;

    always #5 clk = ~clk;

    ipt_search #(.DEPTH(DEPTH), .PID_W(PID_W), .VPN_W(VPN_W)) dut_i (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_slot(ld_slot), .ld_valid(ld_valid),
        .ld_pid(ld_pid), .ld_vpn(ld_vpn), .ld_reject(ld_reject),
        .start(start), .req_pid(req_pid), .req_vpn(req_vpn),
        .busy(busy), .done(done), .fault(fault),
        .ppn(ppn), .scan_cycles(scan_cycles)
    );

    // behavioural reference model
    bit m_valid [DEPTH];
    int m_pid   [DEPTH];
    int m_vpn   [DEPTH];
    bit m_busy, m_done, m_fault;
    int m_ppn, m_cycles, m_remain, p_ppn, p_cycles;
    bit p_fault;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R9";
    bit    finished = 0;

    always @(posedge clk) begin
        bit was_busy;
        was_busy = m_busy;
        if (rst) begin
            foreach (m_valid[i]) begin m_valid[i] = 0; m_pid[i] = 0; m_vpn[i] = 0; end
            m_busy = 0; m_done = 0; m_fault = 0; m_ppn = 0; m_cycles = 0; m_remain = 0;
        end else begin
            m_done = 0;
            if (was_busy) begin
                m_remain--;
                if (m_remain == 0) begin
                    m_busy = 0; m_done = 1;
                    m_fault = p_fault; m_ppn = p_ppn; m_cycles = p_cycles;
                end
            end
            if (!was_busy && ld_en) begin
                m_valid[ld_slot] = ld_valid;
                m_pid[ld_slot]   = ld_pid;
                m_vpn[ld_slot]   = ld_vpn;
            end
            if (!was_busy && start) begin
                int found;
                found = -1;
                for (int i = DEPTH - 1; i >= 0; i--)
                    if (m_valid[i] && m_pid[i] == int'(req_pid) && m_vpn[i] == int'(req_vpn))
                        found = i;
                if (found < 0) begin
                    p_fault = 1; p_ppn = 0; p_cycles = DEPTH;
                end else begin
                    p_fault = 0; p_ppn = found; p_cycles = found + 1;
                end
                m_remain = p_cycles;
                m_busy = 1;
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("busy (R6)", int'(busy), int'(m_busy));
            chk("done (R6/R4)", int'(done), int'(m_done));
            chk("fault (R5)", int'(fault), int'(m_fault));
            chk("ppn (R3)", int'(ppn), m_ppn);
            chk("scan_cycles (R4)", int'(scan_cycles), m_cycles);
            chk("ld_reject (R7)", int'(ld_reject), int'(ld_en && m_busy));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic load(int slot, bit v, int pid, int vpn);
        step();
        ld_en = 1; ld_slot = IDX_W'(slot); ld_valid = v;
        ld_pid = PID_W'(pid); ld_vpn = VPN_W'(vpn);
        step();
        ld_en = 0;
    endtask

    task automatic kick(int pid, int vpn);
        step();
        start = 1; req_pid = PID_W'(pid); req_vpn = VPN_W'(vpn);
        step();
        start = 0;
    endtask

    task automatic wait_idle();
        while (m_busy) step();
        step();
        step();
    endtask

    task automatic search(int pid, int vpn);
        kick(pid, vpn);
        wait_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cur_req = "R9";
        repeat (3) step();
        rst = 0;
        step();

        cur_req = "R1";
        search(1, 'h100);                 // empty table: fault
        load(3, 1, 1, 'h100);
        load(5, 1, 2, 'h100);
        load(9, 1, 1, 'h200);
        load(12, 0, 1, 'h300);
        load(15, 1, 1, 'h300);
        search(1, 'h100);                 // slot 3

        cur_req = "R2";
        search(2, 'h100);                 // pid differs -> slot 5
        search(3, 'h100);                 // no owner -> fault
        search(1, 'h300);                 // invalid 12 skipped -> 15

        cur_req = "R3";
        load(7, 1, 1, 'h200);
        search(1, 'h200);                 // duplicate 7 and 9 -> 7
        load(0, 1, 4, 'h010);
        search(4, 'h010);                 // slot 0, one cycle

        cur_req = "R4";
        search(2, 'h100);
        search(1, 'h300);

        cur_req = "R5";
        search(9, 'h999);
        search(1, 'h101);

        cur_req = "R7";
        kick(1, 'h300);
        step(); ld_en = 1; ld_slot = '0; ld_valid = 1; ld_pid = 1; ld_vpn = 'h300;
        step(); ld_en = 0;
        wait_idle();
        search(1, 'h300);                 // still 15: write was refused
        search(4, 'h010);                 // slot 0 unchanged

        cur_req = "R8";
        kick(1, 'h300);
        start = 1; req_pid = 1; req_vpn = 'h100;
        step(); start = 0;
        wait_idle();

        cur_req = "R9";
        repeat (6) step();
        load(6, 1, 5, 'h555);
        repeat (3) step();
        search(5, 'h555);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule